// File: doc/BRIEF.md
# DSP Peripheral Interrupt and DMA Register Decoder

This block sits on a DSP core's peripheral bus and answers accesses to a handful of addresses near the top of the peripheral space. One address holds an interrupt status word, and four neighbouring addresses are passed through to the register file of a DMA engine. The interrupt word keeps two sticky event flags: one for a frame that has started and one for a frame that was aborted. Pulses from the host side set these flags, and software clears them by writing ones to the bit positions it wants cleared.

The DMA engine's end-of-list indication is not stored here. On every read it is taken live from the engine and shown in bit 7 of the interrupt word. A software clear of bit 7 is turned into a one-cycle clear pulse towards the engine. Any other address in the peripheral space reads back a fixed marker value.

Read data is registered. It is valid, together with a valid strobe, on the cycle after the read request. DMA register writes and the register index go to the engine in the same cycle as the bus access. A level interrupt output is high whenever any reported interrupt bit is 1.

Top module: `dsp_periph_irq`

## Requirements
- R1: After a synchronous reset, the stored interrupt bits are 0, and `rd_data`, `rd_valid`, `dma_eol_clr` and `irq` (with `dma_eol` low) are 0.
- R2: A one-cycle pulse on `frame_start` sets interrupt bit 1, and a pulse on `frame_abort` sets interrupt bit 0. Both bits stay set until software clears them.
- R3: A write to address 0xFFFFC5 clears each stored bit (bit 0, bit 1) that is 1 in the written value. Written bits other than 0, 1 and 7 have no effect.
- R4: A write to 0xFFFFC5 with bit 7 set drives `dma_eol_clr` high for exactly one cycle, starting on the cycle after the write. A write with bit 7 clear produces no pulse.
- R5: A read of 0xFFFFC5 returns bit 0 = abort flag, bit 1 = start flag, bit 7 = the live `dma_eol` input, and all other bits 0.
- R6: When `frame_start` and a clearing write of bit 1 fall in the same cycle, bit 1 ends up set.
- R7: An access to 0xFFFFD4, 0xFFFFD5, 0xFFFFD6 or 0xFFFFD7 drives `dma_idx` with 0, 1, 2 or 3 (the two low address bits) in the same cycle. A write also raises `dma_wr` and forwards `wr_data` on `dma_wdata`, and a read returns `dma_rdata`.
- R8: A read of any other address returns 0x0ABABA. A write to any other address changes no state and raises no `dma_wr`.
- R9: `irq` is 1 exactly when a stored interrupt bit is 1 or `dma_eol` is 1.
- R10: `rd_valid` is high for one cycle, on the cycle after each read request, and is low after writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 24 | Peripheral address |
| wr_data | input | 24 | Write data |
| rd_data | output | 24 | Registered read data |
| rd_valid | output | 1 | Read data valid |
| frame_start | input | 1 | Pulse that sets interrupt bit 1 |
| frame_abort | input | 1 | Pulse that sets interrupt bit 0 |
| irq | output | 1 | Level interrupt request |
| dma_eol | input | 1 | Live end-of-list flag from the DMA engine |
| dma_eol_clr | output | 1 | One-cycle clear pulse for the end-of-list flag |
| dma_idx | output | 2 | DMA register index of the current access |
| dma_wr | output | 1 | DMA register write strobe |
| dma_wdata | output | 24 | DMA register write data |
| dma_rdata | input | 24 | DMA register read data, selected by `dma_idx` |

## Verification
Read data and `rd_valid` come one register stage after the request. The bench pushes each expected read word when it drives the request, and a monitor compares the word at the falling edge after the next rising edge. The DMA strobe, index and write data are combinational and are checked in the same cycle, shortly after the inputs change. The end-of-list clear pulse and the status bits behind `irq` take one register. Their checks sample one falling edge after the triggering access or pulse, and a second falling edge confirms that the clear pulse has dropped.

// File: rtl/dsp_periph_irq_pkg.sv
package dsp_periph_irq_pkg;

  // Bit positions inside the interrupt status word
  localparam int ABORT_BIT = 0;
  localparam int START_BIT = 1;
  localparam int EOL_BIT   = 7;
  localparam int STORED_W  = 2;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_INT  = 2'd1,
    TGT_DMA  = 2'd2
  } tgt_e;

endpackage

// File: rtl/pirq_decode.sv
module pirq_decode
  import dsp_periph_irq_pkg::*;
#(
  parameter int              ADDR_W   = 24,
  parameter logic [ADDR_W-1:0] INT_ADDR = 24'hFFFFC5,
  parameter logic [ADDR_W-1:0] DMA_BASE = 24'hFFFFD4
) (
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  output tgt_e              tgt,
  output logic [1:0]        dma_idx
);

  localparam int DMA_IDX_W = 2;

  logic hit_int;
  logic hit_dma;

  assign hit_int = (addr == INT_ADDR);
  assign hit_dma = (addr[ADDR_W-1:DMA_IDX_W] == DMA_BASE[ADDR_W-1:DMA_IDX_W]);

  always_comb begin
    tgt = TGT_NONE;
    if (sel) begin
      if (hit_int)      tgt = TGT_INT;
      else if (hit_dma) tgt = TGT_DMA;
    end
  end

  assign dma_idx = addr[DMA_IDX_W-1:0] - DMA_BASE[DMA_IDX_W-1:0];

endmodule

// File: rtl/pirq_status.sv
module pirq_status
  import dsp_periph_irq_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr_en,
  input  logic [DATA_W-1:0]   clr_data,
  input  logic                set_start,
  input  logic                set_abort,
  output logic [STORED_W-1:0] stat,
  output logic                eol_clr
);

  logic [STORED_W-1:0] clr_mask;
  logic [STORED_W-1:0] set_mask;
  logic [STORED_W-1:0] stat_d;

  always_comb begin
    clr_mask = '0;
    set_mask = '0;
    if (clr_en) begin
      clr_mask[ABORT_BIT] = clr_data[ABORT_BIT];
      clr_mask[START_BIT] = clr_data[START_BIT];
    end
    set_mask[ABORT_BIT] = set_abort;
    set_mask[START_BIT] = set_start;
    // a set in the same cycle wins over a clear
    stat_d = (stat & ~clr_mask) | set_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat    <= '0;
      eol_clr <= 1'b0;
    end else begin
      stat    <= stat_d;
      eol_clr <= clr_en & clr_data[EOL_BIT];
    end
  end

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
    set_start |=> stat[START_BIT]);

  assert_abort_sets_R2: assert property (@(posedge clk) disable iff (rst)
    set_abort |=> stat[ABORT_BIT]);

  assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
    (clr_en && clr_data[ABORT_BIT] && !set_abort) |=> !stat[ABORT_BIT]);

  assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    !clr_en |=> ((stat & $past(stat)) == $past(stat)));

  assert_eol_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    (clr_en && clr_data[EOL_BIT]) |=> eol_clr);

  assert_eol_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    !(clr_en && clr_data[EOL_BIT]) |=> !eol_clr);

endmodule

// File: rtl/pirq_rdmux.sv
module pirq_rdmux
  import dsp_periph_irq_pkg::*;
#(
  parameter int                DATA_W       = 24,
  parameter logic [DATA_W-1:0] UNMAPPED_VAL = 24'h0ABABA
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en,
  input  tgt_e                tgt,
  input  logic [STORED_W-1:0] stat,
  input  logic                eol,
  input  logic [DATA_W-1:0]   dma_rdata,
  output logic [DATA_W-1:0]   rdata,
  output logic                rvalid
);

  logic [DATA_W-1:0] int_word;
  logic [DATA_W-1:0] rd_d;

  always_comb begin
    int_word            = '0;
    int_word[ABORT_BIT] = stat[ABORT_BIT];
    int_word[START_BIT] = stat[START_BIT];
    int_word[EOL_BIT]   = eol;
  end

  always_comb begin
    unique case (tgt)
      TGT_INT: rd_d = int_word;
      TGT_DMA: rd_d = dma_rdata;
      default: rd_d = UNMAPPED_VAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_d;
    end
  end

  assert_unmapped_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && tgt == TGT_NONE) |=> (rdata == UNMAPPED_VAL));

  assert_rvalid_R10: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid);

  assert_no_rvalid_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rvalid);

endmodule

// File: rtl/dsp_periph_irq.sv
module dsp_periph_irq
  import dsp_periph_irq_pkg::*;
#(
  parameter int                ADDR_W       = 24,
  parameter int                DATA_W       = 24,
  parameter logic [ADDR_W-1:0] INT_ADDR     = 24'hFFFFC5,
  parameter logic [ADDR_W-1:0] DMA_BASE     = 24'hFFFFD4,
  parameter logic [DATA_W-1:0] UNMAPPED_VAL = 24'h0ABABA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              frame_start,
  input  logic              frame_abort,
  output logic              irq,
  input  logic              dma_eol,
  output logic              dma_eol_clr,
  output logic [1:0]        dma_idx,
  output logic              dma_wr,
  output logic [DATA_W-1:0] dma_wdata,
  input  logic [DATA_W-1:0] dma_rdata
);

  tgt_e                tgt;
  logic [STORED_W-1:0] stat;
  logic                rd_en;
  logic                int_wr;

  pirq_decode #(
    .ADDR_W   (ADDR_W),
    .INT_ADDR (INT_ADDR),
    .DMA_BASE (DMA_BASE)
  ) u_decode (
    .sel     (bus_sel),
    .addr    (bus_addr),
    .tgt     (tgt),
    .dma_idx (dma_idx)
  );

  assign rd_en     = bus_sel & ~bus_we;
  assign int_wr    = bus_we & (tgt == TGT_INT);
  assign dma_wr    = bus_we & (tgt == TGT_DMA);
  assign dma_wdata = wr_data;

  pirq_status #(
    .DATA_W (DATA_W)
  ) u_status (
    .clk       (clk),
    .rst       (rst),
    .clr_en    (int_wr),
    .clr_data  (wr_data),
    .set_start (frame_start),
    .set_abort (frame_abort),
    .stat      (stat),
    .eol_clr   (dma_eol_clr)
  );

  pirq_rdmux #(
    .DATA_W       (DATA_W),
    .UNMAPPED_VAL (UNMAPPED_VAL)
  ) u_rdmux (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .tgt       (tgt),
    .stat      (stat),
    .eol       (dma_eol),
    .dma_rdata (dma_rdata),
    .rdata     (rd_data),
    .rvalid    (rd_valid)
  );

  assign irq = (|stat) | dma_eol;

  assert_irq_after_start_R9: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> irq);

  assert_dma_wr_only_mapped_R8: assert property (@(posedge clk) disable iff (rst)
    dma_wr |-> (bus_sel && bus_we));

endmodule

// File: tb/test_dsp_periph_irq.sv
module test_dsp_periph_irq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [23:0] wr_data = '0;
  logic [23:0] rd_data;
  logic        rd_valid;
  logic        frame_start = 1'b0;
  logic        frame_abort = 1'b0;
  logic        irq;
  logic        dma_eol = 1'b0;
  logic        dma_eol_clr;
  logic [1:0]  dma_idx;
  logic        dma_wr;
  logic [23:0] dma_wdata;
  logic [23:0] dma_rdata;

  int checks = 0;
  int errors = 0;
  logic [1:0]  model = 2'b00;
  logic [23:0] exp_q[$];
  string       tag_q[$];
  bit          finished = 0;

  always #2 clk = ~clk;

  // bench-side DMA register file: value encodes the index it was read with
  assign dma_rdata = {4'hD, 18'h0, dma_idx};

  dsp_periph_irq i_dsp_periph_irq (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .wr_data(wr_data), .rd_data(rd_data),
    .rd_valid(rd_valid), .frame_start(frame_start), .frame_abort(frame_abort),
    .irq(irq), .dma_eol(dma_eol), .dma_eol_clr(dma_eol_clr),
    .dma_idx(dma_idx), .dma_wr(dma_wr), .dma_wdata(dma_wdata),
    .dma_rdata(dma_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [23:0] act,
                     input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%06h expected 0x%06h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] int_word();
    return {16'h0, dma_eol, 5'b0, model};
  endfunction

  // Driver: read request, expected word pushed to the scoreboard
  task automatic rd(input logic [23:0] a, input logic [23:0] exp, input string req);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(negedge clk);
    bus_sel = 0;
  endtask

  // Driver: write, optionally with frame_start in the same cycle
  task automatic wr(input logic [23:0] a, input logic [23:0] d, input bit fs);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; wr_data = d; frame_start = fs;
    #1;
    if (a >= 24'hFFFFD4 && a <= 24'hFFFFD7) begin
      chk(dma_wr === 1'b1, "R7 dma_wr", {23'h0, dma_wr}, 24'h1);
      chk(dma_idx === a[1:0], "R7 dma_idx", {22'h0, dma_idx}, {22'h0, a[1:0]});
      chk(dma_wdata === d, "R7 dma_wdata", dma_wdata, d);
    end else begin
      chk(dma_wr === 1'b0, "R8 no dma_wr", {23'h0, dma_wr}, 24'h0);
    end
    if (a == 24'hFFFFC5) model = model & ~d[1:0];
    if (fs) model[1] = 1'b1;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; frame_start = 0;
    chk(rd_valid === 1'b0, "R10 no valid after write", {23'h0, rd_valid}, 24'h0);
  endtask

  task automatic pulse(input bit start, input bit abort_p);
    @(negedge clk);
    frame_start = start; frame_abort = abort_p;
    @(negedge clk);
    frame_start = 0; frame_abort = 0;
    if (start) model[1] = 1'b1;
    if (abort_p) model[0] = 1'b1;
  endtask

  // Monitor: pops scoreboard entries as read results appear
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected rd_valid", 24'h1, 24'h0);
      end else begin
        logic [23:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rd_data === e, t, rd_data, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0x000000 expected 0x000001");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(rd_data === 24'h0, "R1 rd_data", rd_data, 24'h0);
    chk(rd_valid === 1'b0, "R1 rd_valid", {23'h0, rd_valid}, 24'h0);
    chk(irq === 1'b0, "R1 irq", {23'h0, irq}, 24'h0);
    chk(dma_eol_clr === 1'b0, "R1 eol_clr", {23'h0, dma_eol_clr}, 24'h0);
    rd(24'hFFFFC5, 24'h000000, "R1 R5 status after reset");

    // R2 sticky set by pulses, R9 irq follows
    pulse(1, 0);
    chk(irq === 1'b1, "R9 irq after start", {23'h0, irq}, 24'h1);
    repeat (3) @(negedge clk);
    rd(24'hFFFFC5, int_word(), "R2 start bit sticky");
    pulse(0, 1);
    rd(24'hFFFFC5, int_word(), "R2 abort bit");

    // R3 write-one-to-clear
    wr(24'hFFFFC5, 24'h000001, 0);
    chk(dma_eol_clr === 1'b0, "R4 no pulse without bit7", {23'h0, dma_eol_clr}, 24'h0);
    rd(24'hFFFFC5, int_word(), "R3 clear bit0 only");
    wr(24'hFFFFC5, 24'hFFFF7C, 0);
    rd(24'hFFFFC5, int_word(), "R3 other bits no effect");

    // R5 live end-of-list, R4 clear pulse
    dma_eol = 1;
    rd(24'hFFFFC5, int_word(), "R5 eol merged");
    wr(24'hFFFFC5, 24'h000080, 0);
    chk(dma_eol_clr === 1'b1, "R4 pulse high", {23'h0, dma_eol_clr}, 24'h1);
    @(negedge clk);
    chk(dma_eol_clr === 1'b0, "R4 pulse one cycle", {23'h0, dma_eol_clr}, 24'h0);
    rd(24'hFFFFC5, int_word(), "R4 stored bits kept");
    dma_eol = 0;

    // R6 set wins over same-cycle clear
    wr(24'hFFFFC5, 24'h000002, 1);
    rd(24'hFFFFC5, int_word(), "R6 set wins");
    chk(model == 2'b10, "R6 model", {22'h0, model}, 24'h2);

    // R9 irq low when all clear, high on eol alone
    wr(24'hFFFFC5, 24'h000003, 0);
    chk(irq === 1'b0, "R9 irq low", {23'h0, irq}, 24'h0);
    dma_eol = 1;
    #1;
    chk(irq === 1'b1, "R9 irq from eol", {23'h0, irq}, 24'h1);
    dma_eol = 0;

    // R7 DMA registers
    for (int i = 0; i < 4; i++) begin
      wr(24'hFFFFD4 + i, 24'h123400 + i, 0);
      rd(24'hFFFFD4 + i, {4'hD, 18'h0, 2'(i)}, "R7 dma read");
    end

    // R8 unmapped
    rd(24'hFFFFC4, 24'h0ABABA, "R8 unmapped C4");
    rd(24'hFFFFD8, 24'h0ABABA, "R8 unmapped D8");
    rd(24'h000000, 24'h0ABABA, "R8 unmapped 0");
    pulse(1, 1);
    wr(24'hFFFFC6, 24'hFFFFFF, 0);
    rd(24'hFFFFC5, int_word(), "R8 unmapped write no effect");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all reads answered", 24'(exp_q.size()), 24'h0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule